// File: doc/BRIEF.md
# Timed Periodic Pulse Generator

This block turns a free-running precision time value into a train of positive pulses on one output pin. Software sets a start instant as a seconds count plus a nanoseconds count, a repeat period in nanoseconds, a high time in 8 ns units, a repeat limit, a pattern code and a notify flag. It then writes the arm strobe. From the first clock edge at which the incoming time has reached the start instant, the block drives the pin high for the high time and low for the rest of the period. Each later pulse starts one period after the previous one. Nanosecond sums that pass one second carry into the seconds count.

A repeat limit of zero keeps the pulses going until the block is stopped. A nonzero limit ends the train after that many pulses. The block then raises a done flag and, if notify was set, an interrupt flag. Both flags clear only when the matching write-one strobe is pulsed. If the block is armed with a start instant that is not in the future, or with an unsupported pattern code, the error flag rises, the active flag stays set and no pulse is produced. The stop strobe returns the sequencer to idle and clears active and error. It leaves the pin at whatever level it had.

The sequencer has six states. IDLE is entered at reset and on stop. WAIT holds an accepted arm until the start instant. HIGH runs a pulse. LOW runs the gap before the next pulse. FIN follows the last pulse of a limited train. FAULT follows a rejected arm. The transitions are:
- arm, accepted: from any state to WAIT.
- arm, rejected: from any state to FAULT.
- time reaches the start instant: WAIT to HIGH.
- time reaches the pulse end: HIGH to LOW, or HIGH to FIN on the last pulse.
- time reaches the next pulse start: LOW to HIGH.
- stop: from any state to IDLE. Stop takes priority over arm.

Top module: `ptp_pulse_trig`

## Requirements
- R1: After reset the pin, active, done, error and interrupt outputs are all 0.
- R2: After an accepted arm, the pin goes high at the first clock edge at which {now_sec, now_ns} is greater than or equal to {cfg_tgt_sec, cfg_tgt_ns}, compared seconds first.
- R3: Each pulse stays high for cfg_pulse_w8 × 8 ns of input time. Pulse k (counting from 0) starts at the start instant plus k × cfg_cycle_ns. When a nanosecond sum reaches NS_PER_SEC, NS_PER_SEC is subtracted and the seconds count is incremented.
- R4: With cfg_cycles = 0, pulses repeat without limit and done never rises.
- R5: With cfg_cycles = N > 0, the train stops after N pulses. At the edge where the last pulse ends, done rises, the pin is low and active falls. No further pulse follows.
- R6: The interrupt flag rises together with done only if cfg_notify was 1 at arm time.
- R7: A 1 on clr_done clears done, and a 1 on clr_irq clears the interrupt flag. If a clear and a set happen in the same cycle, the set wins.
- R8: An arm whose start instant is not strictly later than the current time sets the error flag. Active stays 1 and the pin does not change.
- R9: An arm with cfg_pattern other than 3'b101 (positive periodic) is rejected in the same way as in R8.
- R10: A 1 on trig_rst clears active and error in the next cycle and leaves the pin level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| now_sec | input | SEC_W | Current time, seconds |
| now_ns | input | NS_W | Current time, nanoseconds (< NS_PER_SEC) |
| cfg_tgt_sec | input | SEC_W | Start instant, seconds |
| cfg_tgt_ns | input | NS_W | Start instant, nanoseconds |
| cfg_cycle_ns | input | NS_W | Period in ns (< NS_PER_SEC) |
| cfg_pulse_w8 | input | PW_W | High time in 8 ns units |
| cfg_cycles | input | CNT_W | Pulse count, 0 = endless |
| cfg_pattern | input | PAT_W | Pattern code, 3'b101 = positive periodic |
| cfg_notify | input | 1 | Raise the interrupt flag on done |
| arm | input | 1 | Strobe: latch the configuration and start |
| trig_rst | input | 1 | Strobe: return to idle, keep the pin level |
| clr_done | input | 1 | Write-one clear of done |
| clr_irq | input | 1 | Write-one clear of the interrupt flag |
| gpio_out | output | 1 | Pulse output |
| active | output | 1 | Unit armed (WAIT, HIGH, LOW or FAULT) |
| done_flag | output | 1 | Limited train finished |
| err_flag | output | 1 | Arm rejected |
| irq_flag | output | 1 | Notify interrupt |

## Verification
The bench builds the block with NS_PER_SEC set to 1000 and keeps the other parameters at their defaults. Its time source advances 8 ns per clock, so an endless train crosses several seconds boundaries within a few hundred cycles. This exercises the nanosecond-to-seconds carry in both the pulse-end and the next-start sums, including a pulse that ends exactly on a seconds boundary. The same scale lets limited trains, rejected arms and stops that land during a high phase all fit in a short run.

// File: rtl/ptp_pulse_trig_pkg.sv
package ptp_pulse_trig_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WAIT  = 3'd1,
        ST_HIGH  = 3'd2,
        ST_LOW   = 3'd3,
        ST_FIN   = 3'd4,
        ST_FAULT = 3'd5
    } trig_state_e;

    localparam logic [2:0] PAT_POS_PERIOD = 3'b101;

endpackage

// File: rtl/ptp_pulse_tadd.sv
// Adds a nanosecond offset (below one second) to a {sec, ns} instant.
module ptp_pulse_tadd #(
    parameter int SEC_W      = 32,
    parameter int NS_W       = 30,
    parameter int ADD_W      = 30,
    parameter int NS_PER_SEC = 1_000_000_000
) (
    input  logic [SEC_W-1:0] a_sec,
    input  logic [NS_W-1:0]  a_ns,
    input  logic [ADD_W-1:0] add_ns,
    output logic [SEC_W-1:0] y_sec,
    output logic [NS_W-1:0]  y_ns
);
    localparam int SUM_W = NS_W + 1;

    logic [SUM_W-1:0] sum;
    logic             wrap;

    always_comb begin
        sum  = SUM_W'(a_ns) + SUM_W'(add_ns);
        wrap = (sum >= SUM_W'(NS_PER_SEC));
        y_ns = wrap ? NS_W'(sum - SUM_W'(NS_PER_SEC)) : NS_W'(sum);
        y_sec = wrap ? (a_sec + SEC_W'(1)) : a_sec;
    end
endmodule

// File: rtl/ptp_pulse_tcmp.sv
// Reports whether instant a is at or after instant b.
module ptp_pulse_tcmp #(
    parameter int SEC_W = 32,
    parameter int NS_W  = 30
) (
    input  logic [SEC_W-1:0] a_sec,
    input  logic [NS_W-1:0]  a_ns,
    input  logic [SEC_W-1:0] b_sec,
    input  logic [NS_W-1:0]  b_ns,
    output logic             a_ge_b
);
    assign a_ge_b = (a_sec > b_sec) || ((a_sec == b_sec) && (a_ns >= b_ns));
endmodule

// File: rtl/ptp_pulse_trig.sv
module ptp_pulse_trig
    import ptp_pulse_trig_pkg::*;
#(
    parameter int SEC_W      = 32,
    parameter int NS_W       = 30,
    parameter int NS_PER_SEC = 1_000_000_000,
    parameter int PW_W       = 24,
    parameter int CNT_W      = 16,
    parameter int PAT_W      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEC_W-1:0] now_sec,
    input  logic [NS_W-1:0]  now_ns,
    input  logic [SEC_W-1:0] cfg_tgt_sec,
    input  logic [NS_W-1:0]  cfg_tgt_ns,
    input  logic [NS_W-1:0]  cfg_cycle_ns,
    input  logic [PW_W-1:0]  cfg_pulse_w8,
    input  logic [CNT_W-1:0] cfg_cycles,
    input  logic [PAT_W-1:0] cfg_pattern,
    input  logic             cfg_notify,
    input  logic             arm,
    input  logic             trig_rst,
    input  logic             clr_done,
    input  logic             clr_irq,
    output logic             gpio_out,
    output logic             active,
    output logic             done_flag,
    output logic             err_flag,
    output logic             irq_flag
);
    localparam int PNS_W = PW_W + 3;

    trig_state_e st_q, st_d;

    logic [SEC_W-1:0] evt_sec_q;
    logic [NS_W-1:0]  evt_ns_q;
    logic [NS_W-1:0]  cyc_q;
    logic [PW_W-1:0]  pw_q;
    logic [CNT_W-1:0] lim_q, cnt_q;
    logic             notify_q;

    logic [SEC_W-1:0] end_sec, nxt_sec, dl_sec;
    logic [NS_W-1:0]  end_ns, nxt_ns, dl_ns;
    logic             hit, tgt_passed, arm_bad, last_pulse;

    ptp_pulse_tadd #(.SEC_W(SEC_W), .NS_W(NS_W), .ADD_W(PNS_W), .NS_PER_SEC(NS_PER_SEC)) u_end_add (
        .a_sec(evt_sec_q), .a_ns(evt_ns_q), .add_ns({pw_q, 3'b000}),
        .y_sec(end_sec), .y_ns(end_ns)
    );

    ptp_pulse_tadd #(.SEC_W(SEC_W), .NS_W(NS_W), .ADD_W(NS_W), .NS_PER_SEC(NS_PER_SEC)) u_nxt_add (
        .a_sec(evt_sec_q), .a_ns(evt_ns_q), .add_ns(cyc_q),
        .y_sec(nxt_sec), .y_ns(nxt_ns)
    );

    always_comb begin
        if (st_q == ST_HIGH) begin
            dl_sec = end_sec;
            dl_ns  = end_ns;
        end else if (st_q == ST_LOW) begin
            dl_sec = nxt_sec;
            dl_ns  = nxt_ns;
        end else begin
            dl_sec = evt_sec_q;
            dl_ns  = evt_ns_q;
        end
    end

    ptp_pulse_tcmp #(.SEC_W(SEC_W), .NS_W(NS_W)) u_hit_cmp (
        .a_sec(now_sec), .a_ns(now_ns), .b_sec(dl_sec), .b_ns(dl_ns), .a_ge_b(hit)
    );

    ptp_pulse_tcmp #(.SEC_W(SEC_W), .NS_W(NS_W)) u_late_cmp (
        .a_sec(now_sec), .a_ns(now_ns), .b_sec(cfg_tgt_sec), .b_ns(cfg_tgt_ns), .a_ge_b(tgt_passed)
    );

    assign arm_bad    = tgt_passed || (cfg_pattern != PAT_W'(PAT_POS_PERIOD));
    assign last_pulse = (lim_q != '0) && ((cnt_q + CNT_W'(1)) == lim_q);

    // next-state logic
    always_comb begin
        st_d = st_q;
        if (trig_rst) begin
            st_d = ST_IDLE;
        end else if (arm) begin
            st_d = arm_bad ? ST_FAULT : ST_WAIT;
        end else begin
            unique case (st_q)
                ST_WAIT: if (hit) st_d = ST_HIGH;
                ST_HIGH: if (hit) st_d = last_pulse ? ST_FIN : ST_LOW;
                ST_LOW:  if (hit) st_d = ST_HIGH;
                default: st_d = st_q;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gpio_out  <= 1'b0;
            done_flag <= 1'b0;
            err_flag  <= 1'b0;
            irq_flag  <= 1'b0;
            evt_sec_q <= '0;
            evt_ns_q  <= '0;
            cyc_q     <= '0;
            pw_q      <= '0;
            lim_q     <= '0;
            cnt_q     <= '0;
            notify_q  <= 1'b0;
        end else begin
            if (clr_done) done_flag <= 1'b0;
            if (clr_irq)  irq_flag  <= 1'b0;
            if (trig_rst) begin
                err_flag <= 1'b0;
            end else if (arm) begin
                evt_sec_q <= cfg_tgt_sec;
                evt_ns_q  <= cfg_tgt_ns;
                cyc_q     <= cfg_cycle_ns;
                pw_q      <= cfg_pulse_w8;
                lim_q     <= cfg_cycles;
                notify_q  <= cfg_notify;
                cnt_q     <= '0;
                err_flag  <= arm_bad;
            end else begin
                unique case (st_q)
                    ST_WAIT: if (hit) gpio_out <= 1'b1;
                    ST_HIGH: if (hit) begin
                        gpio_out <= 1'b0;
                        cnt_q    <= cnt_q + CNT_W'(1);
                        if (last_pulse) begin
                            done_flag <= 1'b1;
                            if (notify_q) irq_flag <= 1'b1;
                        end
                    end
                    ST_LOW: if (hit) begin
                        gpio_out  <= 1'b1;
                        evt_sec_q <= nxt_sec;
                        evt_ns_q  <= nxt_ns;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign active = (st_q == ST_WAIT) || (st_q == ST_HIGH) ||
                    (st_q == ST_LOW)  || (st_q == ST_FAULT);

endmodule

// File: rtl/ptp_pulse_trig_chk.sv
module ptp_pulse_trig_chk (
    input logic clk,
    input logic rst_n,
    input logic trig_rst,
    input logic clr_done,
    input logic gpio_out,
    input logic active,
    input logic done_flag,
    input logic err_flag,
    input logic irq_flag
);
    p_rise_armed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gpio_out) |-> (active && !err_flag));

    p_done_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> (!gpio_out && !active));

    p_irq_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> done_flag);

    p_w1c_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done_flag) |-> $past(clr_done));

    p_fault_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> active);

    p_stop_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        trig_rst |=> (!active && !err_flag));

    p_stop_holds_pin_r10: assert property (@(posedge clk) disable iff (!rst_n)
        trig_rst |=> (gpio_out == $past(gpio_out)));
endmodule

bind ptp_pulse_trig ptp_pulse_trig_chk u_chk (
    .clk(clk), .rst_n(rst_n), .trig_rst(trig_rst), .clr_done(clr_done),
    .gpio_out(gpio_out), .active(active), .done_flag(done_flag),
    .err_flag(err_flag), .irq_flag(irq_flag)
);

// File: tb/sim_ptp_pulse_trig.sv
module sim_ptp_pulse_trig;
    localparam int CLK_PERIOD = 10;
    localparam int NSPS       = 1000;
    localparam int TICK       = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] now_sec = '0;
    logic [29:0] now_ns = '0;
    logic [31:0] cfg_tgt_sec = '0;
    logic [29:0] cfg_tgt_ns = '0;
    logic [29:0] cfg_cycle_ns = '0;
    logic [23:0] cfg_pulse_w8 = '0;
    logic [15:0] cfg_cycles = '0;
    logic [2:0]  cfg_pattern = '0;
    logic        cfg_notify = 1'b0;
    logic        arm = 1'b0, trig_rst = 1'b0, clr_done = 1'b0, clr_irq = 1'b0;
    logic        gpio_out, active, done_flag, err_flag, irq_flag;

    ptp_pulse_trig #(.NS_PER_SEC(NSPS)) u0 (
        .clk(clk), .rst_n(rst_n), .now_sec(now_sec), .now_ns(now_ns),
        .cfg_tgt_sec(cfg_tgt_sec), .cfg_tgt_ns(cfg_tgt_ns), .cfg_cycle_ns(cfg_cycle_ns),
        .cfg_pulse_w8(cfg_pulse_w8), .cfg_cycles(cfg_cycles), .cfg_pattern(cfg_pattern),
        .cfg_notify(cfg_notify), .arm(arm), .trig_rst(trig_rst), .clr_done(clr_done),
        .clr_irq(clr_irq), .gpio_out(gpio_out), .active(active), .done_flag(done_flag),
        .err_flag(err_flag), .irq_flag(irq_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        bit    gpio, act, done, err, irq;
        string req;
    } exp_t;
    exp_t q[$];

    int n_chk = 0, n_bad = 0;

    // bench-side model
    longint t = 0;
    longint m_tgt = 0, m_cyc = 1, m_pw = 0, m_lim = 0;
    bit     m_notify = 0, m_run = 0;
    bit     m_gpio = 0, m_act = 0, m_done = 0, m_err = 0, m_irq = 0;

    function automatic bit model_pin(longint tt);
        longint d, k;
        if (tt < m_tgt) return 1'b0;
        d = tt - m_tgt;
        k = d / m_cyc;
        if (m_lim != 0 && k >= m_lim) return 1'b0;
        return (d % m_cyc) < (m_pw * 8);
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic set_cfg(longint tgt, longint cyc, longint pw, longint lim,
                           logic [2:0] pat, bit ntf);
        cfg_tgt_sec  = 32'(tgt / NSPS);
        cfg_tgt_ns   = 30'(tgt % NSPS);
        cfg_cycle_ns = 30'(cyc);
        cfg_pulse_w8 = 24'(pw);
        cfg_cycles   = 16'(lim);
        cfg_pattern  = pat;
        cfg_notify   = ntf;
    endtask

    // driver: advance time, apply strobes, push the expected result of this edge
    task automatic step(bit a, bit r, bit cd, bit ci, string tag);
        exp_t e;
        @(negedge clk);
        t = t + TICK;
        now_sec = 32'(t / NSPS);
        now_ns  = 30'(t % NSPS);
        arm = a; trig_rst = r; clr_done = cd; clr_irq = ci;
        if (cd) m_done = 0;
        if (ci) m_irq = 0;
        if (r) begin
            m_run = 0; m_act = 0; m_err = 0;
        end else if (a) begin
            m_tgt = longint'(cfg_tgt_sec) * NSPS + longint'(cfg_tgt_ns);
            m_cyc = longint'(cfg_cycle_ns);
            m_pw = longint'(cfg_pulse_w8);
            m_lim = longint'(cfg_cycles);
            m_notify = cfg_notify;
            m_act = 1;
            if (cfg_pattern != 3'b101 || t >= m_tgt) begin
                m_err = 1; m_run = 0;
            end else begin
                m_err = 0; m_run = 1;
            end
        end else if (m_run) begin
            if (m_lim != 0 && t >= m_tgt + (m_lim - 1) * m_cyc + m_pw * 8) begin
                m_done = 1; m_irq = m_irq | m_notify;
                m_run = 0; m_act = 0; m_gpio = 0;
            end else begin
                m_gpio = model_pin(t);
            end
        end
        e.gpio = m_gpio; e.act = m_act; e.done = m_done; e.err = m_err; e.irq = m_irq;
        e.req = tag;
        q.push_back(e);
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, tag);
    endtask

    task automatic hard_reset();
        @(negedge clk);
        arm = 0; trig_rst = 0; clr_done = 0; clr_irq = 0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        m_run = 0; m_gpio = 0; m_act = 0; m_done = 0; m_err = 0; m_irq = 0;
    endtask

    // monitor: compare each result one step after the edge that produced it
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                logic [4:0] act_v, exp_v;
                e = q.pop_front();
                act_v = {gpio_out, active, done_flag, err_flag, irq_flag};
                exp_v = {e.gpio, e.act, e.done, e.err, e.irq};
                n_chk++;
                if (act_v !== exp_v) begin
                    n_bad++;
                    $display("FAIL %s t=%0d {pin,act,done,err,irq} actual=%b expected=%b",
                             e.req, t, act_v, exp_v);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        n_chk++;
        if ({gpio_out, active, done_flag, err_flag, irq_flag} !== 5'b0) begin
            n_bad++;
            $display("FAIL R1 reset actual=%b expected=00000",
                     {gpio_out, active, done_flag, err_flag, irq_flag});
        end
        idle(3, "R1");

        // R2 R3 R4: endless train crossing seconds boundaries (one pulse ends at 1 s exactly)
        set_cfg(200, 240, 10, 0, 3'b101, 1);
        step(1, 0, 0, 0, "R2");
        idle(220, "R3");
        idle(20, "R4");
        // R10: stop during a high phase keeps the pin high
        while (!m_gpio) step(0, 0, 0, 0, "R3");
        step(0, 1, 0, 0, "R10");
        idle(40, "R10");

        hard_reset();

        // R5 R6 R7: three pulses, notify on
        set_cfg(t + 8 + 104, 160, 5, 3, 3'b101, 1);
        step(1, 0, 0, 0, "R2");
        idle(80, "R5");
        step(0, 0, 1, 0, "R7");
        idle(4, "R7");
        step(0, 0, 0, 1, "R7");
        idle(4, "R7");

        // R6: notify off, two pulses
        set_cfg(t + 8 + 64, 96, 4, 2, 3'b101, 0);
        step(1, 0, 0, 0, "R6");
        idle(50, "R6");
        step(0, 0, 1, 0, "R7");
        idle(3, "R7");

        // R8: start already passed
        set_cfg(t + 8 - 40, 96, 4, 0, 3'b101, 1);
        step(1, 0, 0, 0, "R8");
        idle(30, "R8");
        step(0, 1, 0, 0, "R10");
        idle(3, "R10");
        // R8: start equal to current time
        set_cfg(t + 8, 96, 4, 0, 3'b101, 1);
        step(1, 0, 0, 0, "R8");
        idle(10, "R8");
        step(0, 1, 0, 0, "R10");
        idle(3, "R10");

        // R9: unsupported pattern with a future start
        set_cfg(t + 8 + 200, 96, 4, 0, 3'b010, 1);
        step(1, 0, 0, 0, "R9");
        idle(40, "R9");
        step(0, 1, 0, 0, "R10");
        idle(3, "R10");

        repeat (3) @(negedge clk);
        summary();
        $finish;
    end
endmodule